// File: doc/BRIEF.md
# Ray-Major Polar Address Generator

This block turns a polar sampling grid into a stream of word addresses into a Cartesian source matrix held in memory. It walks the grid one ray at a time and visits every point of a ray before it moves on to the next. For each point it emits the four neighbouring source words that a later stage averages. The grid has as many rays as points per ray, and that count is given at start. Software pulses start with a radius, a point count, a matrix base address and a row stride. The block then shows the index of the ray it is working on. The surrounding logic answers that index with the ray's cosine and sine in unsigned Q1.16 fixed point.

Each ray opens with a setup phase. A slow restoring divider, producing one quotient bit per clock, computes the horizontal and vertical per-point increments. A single multiply in setup places the first point. After setup the inner loop reaches each point by adding or subtracting the per-ray increments. The row base address advances by one stride whenever the vertical coordinate crosses an integer, so the stream runs at one address per clock with no multiplier in the loop. Addresses leave through a valid/ready handshake. A one-cycle done pulse marks the end of a scan.

Top module: `ray_addr_gen`

## Requirements
- R1: While reset is asserted and right after it is released, the address valid output is low, the done output is low and the ray index output is 0.
- R2: The ray index output counts 0, 1, … N−1. Every address of ray j is accepted before any address of ray j+1. The cosine and sine inputs are sampled while the ray index output shows the ray they belong to.
- R3: For ray inputs c and s (Q1.16, s nonzero) and radius R, the per-ray increments are dx = floor(R·c·2^16 / ((R+1)·2^16 − R·c)) and dy = floor(R·s·2^16 / ((R+1)·s)). Point k (0 ≤ k ≤ N−1) of the ray sits at x = (N−1)·dx − k·dx and y = k·dy, both in Q16.
- R4: For each point, with a = base + floor(y)·stride + floor(x), four addresses are emitted in the order a, a+1, a+stride, a+stride+1. All addresses are taken modulo 2^ADDR_W.
- R5: While either per-ray division is in progress, address valid stays low. Between the ray index changing (or start) and the first address of that ray, at least 2·(2·FRAC_W+RAD_W+1) cycles pass.
- R6: While valid is high and ready is low, valid stays high and the address output holds its value on the next cycle.
- R7: With ready held high, the 4·N addresses of one ray are accepted on consecutive cycles, one per cycle, with no gap.
- R8: Done is high for exactly one cycle, in the cycle after the last address of the last ray is accepted. Valid is low while done is high.
- R9: A start pulse that arrives while a scan is running is ignored, together with the radius, count, base and stride values present with it. The scan in progress completes unchanged.
- R10: A start with a point count of 0 emits no addresses and raises done in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| radius_i | input | RAD_W | Radius parameter R, latched at start |
| npts_i | input | CNT_W | Point count N (rays and points per ray), latched at start |
| base_i | input | ADDR_W | Matrix base word address, latched at start |
| stride_i | input | ADDR_W | Row stride in words, latched at start |
| cos_i | input | FRAC_W+1 | Cosine of the current ray, unsigned Q1.16 |
| sin_i | input | FRAC_W+1 | Sine of the current ray, unsigned Q1.16, nonzero |
| ray_o | output | CNT_W | Index of the ray in progress |
| addr_valid_o | output | 1 | Address output is valid |
| addr_ready_i | input | 1 | Consumer accepts the address this cycle |
| addr_o | output | ADDR_W | Word address |
| done_o | output | 1 | One-cycle pulse after the final address is accepted |

## Verification
The bench builds the block with its default widths: an 8-bit radius, an 8-bit point count and 24-bit addresses, so each division takes 41 cycles. With these widths a radius of 255 at a cosine of exactly 1.0 is reachable, which drives the horizontal increment to its largest value. The row-crossing logic then meets vertical steps just below one integer. The single-point grid and the empty grid also fall within range, as do rays whose cosine falls steeply enough to spread columns wide across a small matrix.

// File: rtl/rag_pkg.sv
package rag_pkg;

    localparam int FRAC_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_DIVX,
        ST_DIVY,
        ST_FIX,
        ST_RUN
    } rag_state_e;

endpackage

// File: rtl/rag_divider.sv
module rag_divider #(
    parameter int NUM_W = 41,
    parameter int DEN_W = 26,
    parameter int QUO_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [QUO_W-1:0] quot_o
);

    localparam int CNT_B = $clog2(NUM_W + 1);
    localparam int PRD_W = NUM_W + DEN_W;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_B-1:0] cnt;
        logic [NUM_W-1:0] n;
        logic [NUM_W-1:0] numk;
        logic [DEN_W-1:0] den;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] quo;
    } div_regs_t;

    div_regs_t q, d;
    logic [DEN_W:0] trial;
    logic           qbit;

    always_comb begin
        d     = q;
        d.done = 1'b0;
        trial = {q.rem, q.n[NUM_W-1]};
        qbit  = 1'b0;
        if (start_i) begin
            d.busy = 1'b1;
            d.cnt  = CNT_B'(NUM_W);
            d.n    = num_i;
            d.numk = num_i;
            d.den  = den_i;
            d.rem  = '0;
            d.quo  = '0;
        end else if (q.busy) begin
            if (trial >= {1'b0, q.den}) begin
                d.rem = DEN_W'(trial - {1'b0, q.den});
                qbit  = 1'b1;
            end else begin
                d.rem = trial[DEN_W-1:0];
            end
            d.quo = {q.quo[NUM_W-2:0], qbit};
            d.n   = q.n << 1;
            d.cnt = q.cnt - CNT_B'(1);
            if (q.cnt == CNT_B'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = q.busy;
    assign done_o = q.done;
    assign quot_o = q.quo[QUO_W-1:0];

    // R3
    quot_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.den != '0) |->
        (PRD_W'(q.quo) * PRD_W'(q.den) + PRD_W'(q.rem) == PRD_W'(q.numk)) && (q.rem < q.den));

    // R5
    done_idle_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> !q.busy);

endmodule

// File: rtl/rag_quad.sv
module rag_quad #(
    parameter int ADDR_W = 24,
    parameter int COL_W  = 17
) (
    input  logic [ADDR_W-1:0] rowb_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [ADDR_W-1:0] stride_i,
    input  logic [1:0]        sub_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] row_off;

    always_comb begin
        row_off = sub_i[1] ? stride_i : '0;
        addr_o  = rowb_i + ADDR_W'(col_i) + row_off + ADDR_W'(sub_i[0]);
    end

endmodule

// File: rtl/ray_addr_gen.sv
module ray_addr_gen
    import rag_pkg::*;
#(
    parameter int RAD_W  = 8,
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [RAD_W-1:0]    radius_i,
    input  logic [CNT_W-1:0]    npts_i,
    input  logic [ADDR_W-1:0]   base_i,
    input  logic [ADDR_W-1:0]   stride_i,
    input  logic [FRAC_W:0]     cos_i,
    input  logic [FRAC_W:0]     sin_i,
    output logic [CNT_W-1:0]    ray_o,
    output logic                addr_valid_o,
    input  logic                addr_ready_i,
    output logic [ADDR_W-1:0]   addr_o,
    output logic                done_o
);

    localparam int TRIG_W = FRAC_W + 1;
    localparam int RC_W   = RAD_W + TRIG_W;
    localparam int NUM_W  = RC_W + FRAC_W;
    localparam int DEN_W  = RAD_W + 1 + TRIG_W;
    localparam int DX_W   = RAD_W + FRAC_W + 1;
    localparam int X_W    = CNT_W + DX_W;
    localparam int Y_W    = CNT_W + FRAC_W;
    localparam int COL_W  = X_W - FRAC_W;

    typedef struct packed {
        rag_state_e         state;
        logic [RAD_W-1:0]   r;
        logic [CNT_W-1:0]   n;
        logic [ADDR_W-1:0]  base;
        logic [ADDR_W-1:0]  stride;
        logic [CNT_W-1:0]   ray;
        logic [CNT_W-1:0]   k;
        logic [1:0]         sub;
        logic [NUM_W-1:0]   numy;
        logic [DEN_W-1:0]   deny;
        logic [DX_W-1:0]    dx;
        logic [FRAC_W-1:0]  dy;
        logic [X_W-1:0]     x;
        logic [Y_W-1:0]     y;
        logic [ADDR_W-1:0]  rowb;
        logic               done;
    } agen_regs_t;

    agen_regs_t q, d;

    logic              dv_start, dv_busy, dv_done;
    logic [NUM_W-1:0]  dv_num;
    logic [DEN_W-1:0]  dv_den;
    logic [DX_W-1:0]   dv_quot;
    logic [RAD_W:0]    r_plus1;
    logic [RC_W-1:0]   rc_x, rs_y;
    logic [CNT_W-1:0]  n1;
    logic [Y_W-1:0]    y_nx;

    rag_divider #(
        .NUM_W (NUM_W),
        .DEN_W (DEN_W),
        .QUO_W (DX_W)
    ) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (dv_start),
        .num_i   (dv_num),
        .den_i   (dv_den),
        .busy_o  (dv_busy),
        .done_o  (dv_done),
        .quot_o  (dv_quot)
    );

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        dv_start = 1'b0;
        dv_num   = '0;
        dv_den   = '0;
        r_plus1  = {1'b0, q.r} + (RAD_W+1)'(1);
        rc_x     = RC_W'(q.r) * RC_W'(cos_i);
        rs_y     = RC_W'(q.r) * RC_W'(sin_i);
        n1       = q.n - CNT_W'(1);
        y_nx     = q.y + Y_W'(q.dy);
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.r      = radius_i;
                    d.n      = npts_i;
                    d.base   = base_i;
                    d.stride = stride_i;
                    d.ray    = '0;
                    if (npts_i == '0) d.done  = 1'b1;
                    else              d.state = ST_PREP;
                end
            end
            ST_PREP: begin
                dv_start = 1'b1;
                dv_num   = {rc_x, {FRAC_W{1'b0}}};
                dv_den   = DEN_W'({r_plus1, {FRAC_W{1'b0}}}) - DEN_W'(rc_x);
                d.numy   = {rs_y, {FRAC_W{1'b0}}};
                d.deny   = DEN_W'(r_plus1) * DEN_W'(sin_i);
                d.state  = ST_DIVX;
            end
            ST_DIVX: begin
                if (dv_done) begin
                    d.dx     = dv_quot;
                    dv_start = 1'b1;
                    dv_num   = q.numy;
                    dv_den   = q.deny;
                    d.state  = ST_DIVY;
                end
            end
            ST_DIVY: begin
                if (dv_done) begin
                    d.dy    = FRAC_W'(dv_quot);
                    d.state = ST_FIX;
                end
            end
            ST_FIX: begin
                d.x     = X_W'(n1) * X_W'(q.dx);
                d.y     = '0;
                d.rowb  = q.base;
                d.k     = '0;
                d.sub   = '0;
                d.state = ST_RUN;
            end
            ST_RUN: begin
                if (addr_ready_i) begin
                    d.sub = q.sub + 2'd1;
                    if (q.sub == 2'd3) begin
                        if (q.k == n1) begin
                            if (q.ray == n1) begin
                                d.state = ST_IDLE;
                                d.done  = 1'b1;
                            end else begin
                                d.ray   = q.ray + CNT_W'(1);
                                d.state = ST_PREP;
                            end
                        end else begin
                            d.k = q.k + CNT_W'(1);
                            d.x = q.x - X_W'(q.dx);
                            d.y = y_nx;
                            if (y_nx[Y_W-1:FRAC_W] != q.y[Y_W-1:FRAC_W])
                                d.rowb = q.rowb + q.stride;
                        end
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    rag_quad #(
        .ADDR_W (ADDR_W),
        .COL_W  (COL_W)
    ) i_quad (
        .rowb_i   (q.rowb),
        .col_i    (q.x[X_W-1:FRAC_W]),
        .stride_i (q.stride),
        .sub_i    (q.sub),
        .addr_o   (addr_o)
    );

    assign ray_o        = q.ray;
    assign addr_valid_o = (q.state == ST_RUN);
    assign done_o       = q.done;

    // R6
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && !addr_ready_i) |=> (addr_valid_o && $stable(addr_o)));

    // R5
    stall_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dv_busy |-> !addr_valid_o);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !addr_valid_o);

    // R2
    ray_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid_o |-> (ray_o < q.n));

endmodule

// File: tb/test_ray_addr_gen.sv
`timescale 1ns/1ps
module test_ray_addr_gen;

    localparam int RW   = 8;
    localparam int NPW  = 8;
    localparam int AW   = 24;
    localparam int FW   = 16;
    localparam int CW   = FW + 1;
    localparam int DIVC = RW + CW + FW;

    typedef struct packed {
        logic [7:0]  r;
        logic [7:0]  n;
        logic [23:0] base;
        logic [23:0] stride;
        logic [16:0] cstep;
        logic [1:0]  mode;
    } vec_t;

    // mode bit 0: random ready; bit 1: start pulse during scan
    localparam vec_t VECS[6] = '{
        '{8'd3,   8'd4, 24'h001000, 24'd64,  17'd9000,  2'd0},
        '{8'd1,   8'd2, 24'h000000, 24'd16,  17'd30000, 2'd1},
        '{8'd7,   8'd5, 24'h020000, 24'd100, 17'd5000,  2'd1},
        '{8'd255, 8'd3, 24'h000400, 24'd300, 17'd20000, 2'd0},
        '{8'd2,   8'd1, 24'h000050, 24'd10,  17'd0,     2'd0},
        '{8'd5,   8'd3, 24'h003000, 24'd40,  17'd12000, 2'd3}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst_n;
    logic           start_i;
    logic [RW-1:0]  radius_i;
    logic [NPW-1:0] npts_i;
    logic [AW-1:0]  base_i, stride_i;
    logic [CW-1:0]  cos_in, sin_in;
    logic [NPW-1:0] ray_o;
    logic           valid, ready, done_o;
    logic [AW-1:0]  addr;
    logic [16:0]    cstep_cur;
    logic [15:0]    lfsr;

    int total = 0;
    int bad   = 0;

    assign cos_in = CW'(65536 - int'(ray_o) * int'(cstep_cur));
    assign sin_in = CW'(4096 + int'(ray_o) * 7000);

    ray_addr_gen i_ray_addr_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .radius_i     (radius_i),
        .npts_i       (npts_i),
        .base_i       (base_i),
        .stride_i     (stride_i),
        .cos_i        (cos_in),
        .sin_i        (sin_in),
        .ray_o        (ray_o),
        .addr_valid_o (valid),
        .addr_ready_i (ready),
        .addr_o       (addr),
        .done_o       (done_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint exp_addr(input vec_t v, input int j, input int k, input int s);
        longint r   = longint'(v.r);
        longint c   = 65536 - longint'(j) * longint'(v.cstep);
        longint sn  = 4096 + longint'(j) * 7000;
        longint n1  = longint'(v.n) - 1;
        longint dx  = (r * c * 65536) / ((r + 1) * 65536 - r * c);
        longint dy  = (r * sn * 65536) / ((r + 1) * sn);
        longint x   = n1 * dx - longint'(k) * dx;
        longint y   = longint'(k) * dy;
        longint a   = longint'(v.base) + (y >>> 16) * longint'(v.stride) + (x >>> 16)
                      + ((s >= 2) ? longint'(v.stride) : 0) + longint'(s % 2);
        return a % (longint'(1) << AW);
    endfunction

    task automatic run_scan(input vec_t v);
        int     waits;
        bit     stall;
        bit     bubble;
        int     bad0;
        logic [AW-1:0] held;
        @(negedge clk);
        radius_i  = v.r;
        npts_i    = v.n;
        base_i    = v.base;
        stride_i  = v.stride;
        cstep_cur = v.cstep;
        start_i   = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        if (v.n == 0) begin
            check(done_o === 1'b1 && valid === 1'b0, "R10 done after empty start", {done_o, valid}, 2'b10);
            @(negedge clk); #1;
            check(done_o === 1'b0 && valid === 1'b0, "R10 no stream after empty start", {done_o, valid}, 2'b00);
            return;
        end
        bad0  = bad;
        stall = 1'b0;
        held  = '0;
        for (int j = 0; j < int'(v.n); j++) begin
            bubble = 1'b0;
            for (int k = 0; k < int'(v.n); k++) begin
                for (int s = 0; s < 4; s++) begin
                    waits = 0;
                    forever begin
                        @(negedge clk);
                        start_i = 1'b0;
                        ready   = v.mode[0] ? lfsr[0] : 1'b1;
                        lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                        #1;
                        waits++;
                        if (stall)
                            check(valid === 1'b1 && addr === held, "R6 hold under backpressure", addr, held);
                        stall = valid && !ready;
                        held  = addr;
                        if (valid && ready) break;
                    end
                    check(longint'(addr) == exp_addr(v, j, k, s), "R4 address value", addr, exp_addr(v, j, k, s));
                    if (s == 0)
                        check(int'(ray_o) == j, "R2 ray order", ray_o, j);
                    if (k == 0 && s == 0)
                        check(waits >= 2 * DIVC, "R5 setup stall length", waits, 2 * DIVC);
                    else if (waits != 1)
                        bubble = 1'b1;
                    if (v.mode[1] && j == 1 && k == 0 && s == 0) begin
                        start_i  = 1'b1;
                        radius_i = v.r + 8'd1;
                        base_i   = '0;
                        npts_i   = 8'd9;
                    end
                end
            end
            if (!v.mode[0])
                check(!bubble, "R7 one address per cycle", bubble, 0);
        end
        @(negedge clk);
        ready = 1'b1;
        #1;
        check(done_o === 1'b1 && valid === 1'b0, "R8 done after last accept", {done_o, valid}, 2'b10);
        @(negedge clk); #1;
        check(done_o === 1'b0, "R8 done lasts one cycle", done_o, 0);
        if (v.mode[1])
            check(bad == bad0, "R9 busy start ignored", bad - bad0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        start_i   = 1'b0;
        radius_i  = '0;
        npts_i    = '0;
        base_i    = '0;
        stride_i  = '0;
        cstep_cur = '0;
        ready     = 1'b0;
        lfsr      = 16'hACE1;
        repeat (3) @(negedge clk);
        #1;
        // R1 during reset
        check(valid === 1'b0 && done_o === 1'b0 && ray_o === '0, "R1 reset state", {valid, done_o, ray_o}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 after release
        check(valid === 1'b0 && done_o === 1'b0 && ray_o === '0, "R1 after release", {valid, done_o, ray_o}, 0);

        for (int i = 0; i < 6; i++)
            run_scan(VECS[i]);

        // R10 empty grid
        run_scan('{8'd4, 8'd0, 24'h000100, 24'd8, 17'd1000, 2'd0});
        // R3 reuse after empty grid: single short scan
        run_scan('{8'd6, 8'd2, 24'h000200, 24'd32, 17'd25000, 2'd0});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule